// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits on the address path in front of a memory slave. It compares every read and write address beat against a bank of programmable regions. Each region has an inclusive start and end bound, a master-ID value and mask, separate read and write enables, and a secure attribute. A beat that no region allows is not stopped here. It goes downstream unchanged, except that sideband user bit 10 is forced high as a poison mark, so the memory endpoint can reject it. The block also records the first offending beat and raises an interrupt.

A small APB-style register port programs the regions, reads the violation record and clears the interrupt. Only one designated configuration master may write. A sticky lock bit freezes every writable register, including the interrupt clear. Region bounds have a granule of 1 MB or 4 KB, chosen by a parameter. Address bits below the granule are dropped from both bounds.

Register offsets: 0x000 control (bit 0 lock, bit 1 interrupt enable), 0x004 status (bit 0 captured, bit 1 overflow, bit 2 captured beat was a write), 0x008 captured address, 0x00C captured master ID, 0x010 clear (write bit 0 = 1). Region n starts at 0x100 + 16·n and holds four words: +0 start, +4 end, +8 ID (value in bits [ID_W-1:0], mask in bits [16+ID_W-1:16]), +C attributes (bit 0 enable, bit 1 read allowed, bit 2 write allowed, bit 3 secure).

Top module: `mem_guard`

## Requirements
- R1: A beat passes an enabled region only when its address lies between that region's start and end, both ends included. An address one byte outside either bound is poisoned.
- R2: The low GRAN_SHIFT bits of start and end (12 for the 4 KB granule, 20 for the 1 MB granule) are dropped on write and read back as zero. The end bound therefore covers its whole last granule.
- R3: The master ID matches a region when (id & mask) == (value & mask). A beat whose ID does not match is poisoned.
- R4: A read needs the region's read-allowed bit, and a write needs its write-allowed bit. A write to a read-only region is poisoned.
- R5: A beat with in_prot[1]=1 (non-secure) may not pass a region marked secure. A beat with in_prot[1]=0 may pass secure and non-secure regions.
- R6: A beat that hits no region is poisoned. When regions overlap, one passing region is enough.
- R7: Every beat is forwarded in the same cycle with address, ID, direction and protection unchanged. out_user equals in_user with bit 10 ORed with the violation.
- R8: The first violating handshake (in_valid and out_ready) records its address, ID and direction. Any later violating handshake sets overflow and keeps the first record. irq rises one cycle after the first violation when the interrupt enable is set.
- R9: Writing 1 to bit 0 of the clear register zeroes the status and drops irq on the next cycle.
- R10: Once lock is set it stays set. Every later write, including the clear, is ignored and answered with pslverr.
- R11: A write whose pmaster_id differs from OWNER_ID is ignored and answered with pslverr.
- R12: After reset all regions are disabled, so every beat is poisoned. Status, control and irq read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream address beat valid |
| in_ready | output | 1 | Upstream ready, equal to out_ready |
| in_addr | input | ADDR_W | Beat address |
| in_id | input | ID_W | Beat master ID |
| in_write | input | 1 | 1 = write, 0 = read |
| in_prot | input | 3 | Protection bits; bit 1 = non-secure |
| in_user | input | USER_W | User sideband |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream ready |
| out_addr | output | ADDR_W | Forwarded address |
| out_id | output | ID_W | Forwarded ID |
| out_write | output | 1 | Forwarded direction |
| out_prot | output | 3 | Forwarded protection |
| out_user | output | USER_W | Forwarded user bits, bit 10 = poison |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register write |
| paddr | input | 12 | Register byte address |
| pwdata | input | 32 | Register write data |
| pmaster_id | input | ID_W | ID of the register-port master |
| prdata | output | 32 | Register read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error on a refused write |
| irq | output | 1 | Violation interrupt |

## Verification
The bench builds the block with the 4 KB granule and four regions. Bound edges then sit at small, readable addresses, and the whole region bank can be programmed and probed with one short table. Four regions are enough to set up an ID-masked region, a read-only region, a secure region, and an overlap where a second region rescues a write the first refuses. The default 1 MB granule and sixteen regions use the same generate structure and are only elaborated.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;
  localparam int PADDR_W   = 12;
  localparam int PDATA_W   = 32;
  // fixed register offsets
  localparam logic [PADDR_W-1:0] OFF_CTRL  = 12'h000;
  localparam logic [PADDR_W-1:0] OFF_STAT  = 12'h004;
  localparam logic [PADDR_W-1:0] OFF_EADDR = 12'h008;
  localparam logic [PADDR_W-1:0] OFF_EID   = 12'h00C;
  localparam logic [PADDR_W-1:0] OFF_CLR   = 12'h010;
  localparam logic [PADDR_W-1:0] RGN_BASE  = 12'h100;
  localparam int RGN_STRIDE_SH = 4;
  // word select inside a region
  typedef enum logic [1:0] {W_START = 2'd0, W_END = 2'd1, W_ID = 2'd2, W_ATTR = 2'd3} rgn_word_e;
  // attribute bits
  localparam int A_EN  = 0;
  localparam int A_RD  = 1;
  localparam int A_WR  = 2;
  localparam int A_SEC = 3;
  localparam int ATTR_W = 4;
  // control bits
  localparam int C_LOCK  = 0;
  localparam int C_IRQEN = 1;
  // sideband positions
  localparam int POISON_BIT  = 10;
  localparam int PROT_NS_BIT = 1;
  localparam int ID_MASK_LSB = 16;
endpackage

// File: rtl/mg_regfile.sv
module mg_regfile
  import mem_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  parameter int ID_W        = 10,
  parameter int GRAN_SHIFT  = 20,
  parameter logic [ID_W-1:0] OWNER_ID = '0,
  localparam int GW = ADDR_W - GRAN_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [PADDR_W-1:0]  paddr,
  input  logic [PDATA_W-1:0]  pwdata,
  input  logic [ID_W-1:0]     pmaster_id,
  output logic [PDATA_W-1:0]  prdata,
  output logic                pslverr,
  output logic [GW-1:0]       rgn_start [NUM_REGIONS],
  output logic [GW-1:0]       rgn_end   [NUM_REGIONS],
  output logic [ID_W-1:0]     rgn_idv   [NUM_REGIONS],
  output logic [ID_W-1:0]     rgn_idm   [NUM_REGIONS],
  output logic [ATTR_W-1:0]   rgn_attr  [NUM_REGIONS],
  output logic                lock,
  output logic                irq_en,
  output logic                clr_pulse,
  input  logic                st_valid,
  input  logic                st_ovf,
  input  logic                st_write,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic [ID_W-1:0]     st_id
);
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [PADDR_W-1:0] RGN_SPAN = PADDR_W'(NUM_REGIONS << RGN_STRIDE_SH);

  logic wr_try, owner_ok, wr_acc;
  logic [PADDR_W-1:0] roff;
  logic in_rgn;
  logic [RIDX_W-1:0] ridx;
  rgn_word_e rword;

  assign wr_try   = psel & penable & pwrite;
  assign owner_ok = (pmaster_id == OWNER_ID);
  assign wr_acc   = wr_try & owner_ok & ~lock;
  assign pslverr  = wr_try & (~owner_ok | lock);

  assign roff   = paddr - RGN_BASE;
  assign in_rgn = (paddr >= RGN_BASE) && (roff < RGN_SPAN);
  assign ridx   = roff[RGN_STRIDE_SH +: RIDX_W];
  assign rword  = rgn_word_e'(paddr[3:2]);

  // control register
  logic lock_d, irq_en_d, ctrl_we;
  assign ctrl_we   = wr_acc && (paddr == OFF_CTRL);
  assign clr_pulse = wr_acc && (paddr == OFF_CLR) && pwdata[0];

  always_comb begin
    lock_d   = lock;
    irq_en_d = irq_en;
    if (ctrl_we) begin
      lock_d   = lock | pwdata[C_LOCK];
      irq_en_d = pwdata[C_IRQEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock   <= 1'b0;
      irq_en <= 1'b0;
    end else if (ctrl_we) begin
      lock   <= lock_d;
      irq_en <= irq_en_d;
    end
  end

  // region bank
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    logic sel, we_s, we_e, we_i, we_a;
    logic [GW-1:0] start_d, end_d;
    logic [ID_W-1:0] idv_d, idm_d;
    logic [ATTR_W-1:0] attr_d;

    assign sel  = wr_acc && in_rgn && (ridx == RIDX_W'(r));
    assign we_s = sel && (rword == W_START);
    assign we_e = sel && (rword == W_END);
    assign we_i = sel && (rword == W_ID);
    assign we_a = sel && (rword == W_ATTR);

    always_comb begin
      start_d = we_s ? pwdata[ADDR_W-1:GRAN_SHIFT] : rgn_start[r];
      end_d   = we_e ? pwdata[ADDR_W-1:GRAN_SHIFT] : rgn_end[r];
      idv_d   = we_i ? pwdata[ID_W-1:0] : rgn_idv[r];
      idm_d   = we_i ? pwdata[ID_MASK_LSB +: ID_W] : rgn_idm[r];
      attr_d  = we_a ? pwdata[ATTR_W-1:0] : rgn_attr[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rgn_start[r] <= '0;
        rgn_end[r]   <= '0;
        rgn_idv[r]   <= '0;
        rgn_idm[r]   <= '0;
        rgn_attr[r]  <= '0;
      end else if (sel) begin
        rgn_start[r] <= start_d;
        rgn_end[r]   <= end_d;
        rgn_idv[r]   <= idv_d;
        rgn_idm[r]   <= idm_d;
        rgn_attr[r]  <= attr_d;
      end
    end
  end

  // read mux
  always_comb begin
    prdata = '0;
    if (in_rgn) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (ridx == RIDX_W'(r)) begin
          case (rword)
            W_START: prdata[ADDR_W-1:0] = {rgn_start[r], {GRAN_SHIFT{1'b0}}};
            W_END:   prdata[ADDR_W-1:0] = {rgn_end[r], {GRAN_SHIFT{1'b0}}};
            W_ID: begin
              prdata[ID_W-1:0]              = rgn_idv[r];
              prdata[ID_MASK_LSB +: ID_W]   = rgn_idm[r];
            end
            default: prdata[ATTR_W-1:0] = rgn_attr[r];
          endcase
        end
      end
    end else begin
      case (paddr)
        OFF_CTRL:  begin prdata[C_LOCK] = lock; prdata[C_IRQEN] = irq_en; end
        OFF_STAT:  prdata[2:0] = {st_write, st_ovf, st_valid};
        OFF_EADDR: prdata[ADDR_W-1:0] = st_addr;
        OFF_EID:   prdata[ID_W-1:0] = st_id;
        default:   prdata = '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{pwdata, paddr[1:0]};
endmodule

// File: rtl/mg_region_match.sv
module mg_region_match
  import mem_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  parameter int ID_W        = 10,
  parameter int GRAN_SHIFT  = 20,
  localparam int GW = ADDR_W - GRAN_SHIFT
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ID_W-1:0]    id,
  input  logic               is_write,
  input  logic               non_secure,
  input  logic [GW-1:0]      rgn_start [NUM_REGIONS],
  input  logic [GW-1:0]      rgn_end   [NUM_REGIONS],
  input  logic [ID_W-1:0]    rgn_idv   [NUM_REGIONS],
  input  logic [ID_W-1:0]    rgn_idm   [NUM_REGIONS],
  input  logic [ATTR_W-1:0]  rgn_attr  [NUM_REGIONS],
  output logic               allowed
);
  logic [GW-1:0] gaddr;
  logic [NUM_REGIONS-1:0] pass_vec;

  assign gaddr = addr[ADDR_W-1:GRAN_SHIFT];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    logic in_range, id_hit, dir_ok, sec_ok;
    assign in_range = (gaddr >= rgn_start[r]) && (gaddr <= rgn_end[r]);
    assign id_hit   = ((id & rgn_idm[r]) == (rgn_idv[r] & rgn_idm[r]));
    assign dir_ok   = is_write ? rgn_attr[r][A_WR] : rgn_attr[r][A_RD];
    assign sec_ok   = ~(non_secure & rgn_attr[r][A_SEC]);
    assign pass_vec[r] = rgn_attr[r][A_EN] & in_range & id_hit & dir_ok & sec_ok;
  end

  assign allowed = |pass_vec;

  logic unused_low;
  assign unused_low = ^addr[GRAN_SHIFT-1:0];
endmodule

// File: rtl/mg_violation_log.sv
module mg_violation_log #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol_hs,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]   id,
  input  logic              is_write,
  input  logic              clr,
  input  logic              irq_en,
  output logic              st_valid,
  output logic              st_ovf,
  output logic              st_write,
  output logic [ADDR_W-1:0] st_addr,
  output logic [ID_W-1:0]   st_id,
  output logic              irq
);
  logic valid_d, ovf_d, cap_en, flag_en;

  // a new violation in the clear cycle wins and starts a fresh record
  assign cap_en  = viol_hs & (~st_valid | clr);
  assign flag_en = viol_hs | clr;

  always_comb begin
    valid_d = st_valid;
    ovf_d   = st_ovf;
    if (clr) begin
      valid_d = 1'b0;
      ovf_d   = 1'b0;
    end
    if (viol_hs) begin
      if (cap_en) valid_d = 1'b1;
      else        ovf_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_ovf   <= 1'b0;
    end else if (flag_en) begin
      st_valid <= valid_d;
      st_ovf   <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_addr  <= '0;
      st_id    <= '0;
      st_write <= 1'b0;
    end else if (cap_en) begin
      st_addr  <= addr;
      st_id    <= id;
      st_write <= is_write;
    end else if (clr) begin
      st_addr  <= '0;
      st_id    <= '0;
      st_write <= 1'b0;
    end
  end

  assign irq = st_valid & irq_en;
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mem_guard_pkg::*;
#(
  parameter int NUM_REGIONS   = 16,
  parameter int ADDR_W        = 32,
  parameter int ID_W          = 10,
  parameter int USER_W        = 16,
  parameter bit LARGE_GRANULE = 1'b1,
  parameter logic [ID_W-1:0] OWNER_ID = 10'h001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [ID_W-1:0]    in_id,
  input  logic               in_write,
  input  logic [2:0]         in_prot,
  input  logic [USER_W-1:0]  in_user,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [ID_W-1:0]    out_id,
  output logic               out_write,
  output logic [2:0]         out_prot,
  output logic [USER_W-1:0]  out_user,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [11:0]        paddr,
  input  logic [31:0]        pwdata,
  input  logic [ID_W-1:0]    pmaster_id,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  output logic               irq
);
  localparam int GRAN_SHIFT = LARGE_GRANULE ? 20 : 12;
  localparam int GW = ADDR_W - GRAN_SHIFT;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [GW-1:0]     rgn_start [NUM_REGIONS];
  logic [GW-1:0]     rgn_end   [NUM_REGIONS];
  logic [ID_W-1:0]   rgn_idv   [NUM_REGIONS];
  logic [ID_W-1:0]   rgn_idm   [NUM_REGIONS];
  logic [ATTR_W-1:0] rgn_attr  [NUM_REGIONS];
  logic lock, irq_en, clr_pulse;
  logic st_valid, st_ovf, st_write;
  logic [ADDR_W-1:0] st_addr;
  logic [ID_W-1:0] st_id;
  logic allowed, viol, hs;

  mg_regfile #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .ID_W(ID_W),
    .GRAN_SHIFT(GRAN_SHIFT), .OWNER_ID(OWNER_ID)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .pmaster_id(pmaster_id), .prdata(prdata), .pslverr(pslverr),
    .rgn_start(rgn_start), .rgn_end(rgn_end), .rgn_idv(rgn_idv),
    .rgn_idm(rgn_idm), .rgn_attr(rgn_attr),
    .lock(lock), .irq_en(irq_en), .clr_pulse(clr_pulse),
    .st_valid(st_valid), .st_ovf(st_ovf), .st_write(st_write),
    .st_addr(st_addr), .st_id(st_id)
  );

  mg_region_match #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .ID_W(ID_W), .GRAN_SHIFT(GRAN_SHIFT)
  ) u_match (
    .addr(in_addr), .id(in_id), .is_write(in_write),
    .non_secure(in_prot[PROT_NS_BIT]),
    .rgn_start(rgn_start), .rgn_end(rgn_end), .rgn_idv(rgn_idv),
    .rgn_idm(rgn_idm), .rgn_attr(rgn_attr), .allowed(allowed)
  );

  assign viol = ~allowed;
  assign hs   = in_valid & out_ready;

  mg_violation_log #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_log (
    .clk(clk), .rst_n(rst_sync_n),
    .viol_hs(hs & viol), .addr(in_addr), .id(in_id), .is_write(in_write),
    .clr(clr_pulse), .irq_en(irq_en),
    .st_valid(st_valid), .st_ovf(st_ovf), .st_write(st_write),
    .st_addr(st_addr), .st_id(st_id), .irq(irq)
  );

  // forward path: unchanged except the poison attribute
  always_comb begin
    out_user             = in_user;
    out_user[POISON_BIT] = in_user[POISON_BIT] | viol;
  end
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_addr  = in_addr;
  assign out_id    = in_id;
  assign out_write = in_write;
  assign out_prot  = in_prot;
  assign pready    = 1'b1;
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 10,
  parameter int USER_W = 16,
  parameter logic [ID_W-1:0] OWNER_ID = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              viol,
  input logic              hs,
  input logic [USER_W-1:0] out_user,
  input logic              st_valid,
  input logic              st_ovf,
  input logic [ADDR_W-1:0] st_addr,
  input logic              clr_pulse,
  input logic              lock,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ID_W-1:0]   pmaster_id,
  input logic              pslverr,
  input logic              irq
);
  // R7
  poison_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && viol |-> out_user[10]);
  // R8
  capture_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_valid) |-> $past(hs && viol));
  // R8
  ovf_with_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_ovf |-> st_valid);
  // R8
  first_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !clr_pulse |=> $stable(st_addr));
  // R9
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse && !(hs && viol) |=> !irq);
  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  // R10
  locked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psel && penable && pwrite && lock |-> pslverr);
  // R11
  foreign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psel && penable && pwrite && (pmaster_id != OWNER_ID) |-> pslverr);
endmodule

bind mem_guard mem_guard_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .USER_W(USER_W), .OWNER_ID(OWNER_ID)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .viol(viol), .hs(hs),
  .out_user(out_user), .st_valid(st_valid), .st_ovf(st_ovf), .st_addr(st_addr),
  .clr_pulse(clr_pulse), .lock(lock), .psel(psel), .penable(penable),
  .pwrite(pwrite), .pmaster_id(pmaster_id), .pslverr(pslverr), .irq(irq)
);

// File: tb/mem_guard_tb.sv
module mem_guard_tb;
  localparam int AW = 32;
  localparam int IW = 10;
  localparam int UW = 16;
  localparam logic [IW-1:0] OWN = 10'h001;
  localparam logic [IW-1:0] OTHER = 10'h002;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_write, out_valid, out_ready, out_write;
  logic [AW-1:0] in_addr, out_addr;
  logic [IW-1:0] in_id, out_id, pmaster_id;
  logic [2:0] in_prot, out_prot;
  logic [UW-1:0] in_user, out_user;
  logic psel, penable, pwrite, pready, pslverr, irq;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  mem_guard #(
    .NUM_REGIONS(4), .ADDR_W(AW), .ID_W(IW), .USER_W(UW),
    .LARGE_GRANULE(1'b0), .OWNER_ID(OWN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_id(in_id),
    .in_write(in_write), .in_prot(in_prot), .in_user(in_user),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_id(out_id),
    .out_write(out_write), .out_prot(out_prot), .out_user(out_user),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .pmaster_id(pmaster_id), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one register access; err and rdata taken in the access phase
  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [IW-1:0] mid, output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pmaster_id = mid;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd;
    logic e;
    apb(1'b1, a, d, OWN, rd, e);
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] rd);
    logic e;
    apb(1'b0, a, 32'h0, OWN, rd, e);
  endtask

  // beat: addr, id, write, prot, user, expected poison
  localparam int VN = 14;
  localparam logic [62:0] VEC [VN] = '{
    {32'h0001_0000, 10'h020, 1'b0, 3'd0, 16'h00A5, 1'b0}, // R1 lower bound
    {32'h0001_3FFF, 10'h02F, 1'b1, 3'd0, 16'h00A5, 1'b0}, // R2 last byte of end granule
    {32'h0001_4000, 10'h020, 1'b0, 3'd0, 16'h00A5, 1'b1}, // R1 one past end
    {32'h0000_FFFF, 10'h020, 1'b0, 3'd0, 16'h00A5, 1'b1}, // R1 one below start
    {32'h0001_1000, 10'h030, 1'b0, 3'd0, 16'h00A5, 1'b1}, // R3 id mismatch
    {32'h0001_1000, 10'h12A, 1'b0, 3'd0, 16'h00A5, 1'b1}, // R3 masked upper bits differ
    {32'h2000_0010, 10'h001, 1'b0, 3'd0, 16'h00A5, 1'b0}, // R4 read of read-only
    {32'h2000_0010, 10'h001, 1'b1, 3'd0, 16'h00A5, 1'b1}, // R4 write of read-only
    {32'h2000_0010, 10'h055, 1'b1, 3'd0, 16'h00A5, 1'b0}, // R6 overlap rescues
    {32'h3000_0100, 10'h001, 1'b0, 3'd2, 16'h00A5, 1'b1}, // R5 non-secure to secure
    {32'h3000_0100, 10'h001, 1'b1, 3'd0, 16'h00A5, 1'b0}, // R5 secure to secure
    {32'h2000_0010, 10'h001, 1'b0, 3'd2, 16'h00A5, 1'b0}, // R5 non-secure to non-secure
    {32'h4000_0000, 10'h001, 1'b0, 3'd0, 16'h00A5, 1'b1}, // R6 no region
    {32'h2000_0010, 10'h001, 1'b0, 3'd0, 16'h04A5, 1'b0}  // R7 incoming bit 10 kept
  };

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=%0d expected<50000", cycles);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    logic err;
    rst_n = 1'b0;
    in_valid = 1'b0; in_addr = '0; in_id = '0; in_write = 1'b0; in_prot = '0; in_user = '0;
    out_ready = 1'b0;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0; pmaster_id = OWN;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 irq", {31'd0, irq}, 32'd0);
    rd_reg(12'h004, rd); check("R12 status", rd, 32'd0);
    rd_reg(12'h000, rd); check("R12 control", rd, 32'd0);
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h0001_0000; in_id = 10'h020; in_user = 16'h0;
    #1; check("R12 all regions off -> poison", {31'd0, out_user[10]}, 32'd1);
    @(negedge clk); in_valid = 1'b0;

    // program regions
    wr_reg(12'h100, 32'h0001_0ABC); wr_reg(12'h104, 32'h0001_3000);
    wr_reg(12'h108, 32'h03F0_0020); wr_reg(12'h10C, 32'h7);
    wr_reg(12'h110, 32'h2000_0000); wr_reg(12'h114, 32'h2000_0FFF);
    wr_reg(12'h118, 32'h0);         wr_reg(12'h11C, 32'h3);
    wr_reg(12'h120, 32'h3000_0000); wr_reg(12'h124, 32'h3000_1FFF);
    wr_reg(12'h128, 32'h0);         wr_reg(12'h12C, 32'hF);
    wr_reg(12'h130, 32'h2000_0000); wr_reg(12'h134, 32'h2000_0FFF);
    wr_reg(12'h138, 32'h03FF_0055); wr_reg(12'h13C, 32'h7);
    rd_reg(12'h100, rd); check("R2 start low bits dropped", rd, 32'h0001_0000);
    rd_reg(12'h108, rd); check("R3 id word readback", rd, 32'h03F0_0020);

    // table walk (no handshake, so nothing is logged)
    for (int i = 0; i < VN; i++) begin
      logic [62:0] v;
      logic [UW-1:0] exp_user;
      v = VEC[i];
      @(negedge clk);
      in_valid = 1'b1; in_addr = v[62:31]; in_id = v[30:21]; in_write = v[20];
      in_prot = v[19:17]; in_user = v[16:1];
      exp_user = v[16:1] | (UW'(v[0]) << 10);
      #1;
      check($sformatf("R1-6 vec%0d poison/user (R7)", i), {16'd0, out_user}, {16'd0, exp_user});
      check($sformatf("R7 vec%0d addr", i), out_addr, v[62:31]);
      check($sformatf("R7 vec%0d id/dir/prot/valid", i),
            {18'd0, out_id, out_write, out_prot, out_valid},
            {18'd0, v[30:21], v[20], v[19:17], 1'b1});
    end
    @(negedge clk); in_valid = 1'b0; in_user = '0;

    // R8 capture and overflow
    wr_reg(12'h000, 32'h2);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h4000_0000; in_id = 10'h033; in_write = 1'b1; in_prot = 3'd0;
    #1; check("R8 no irq before capture edge", {31'd0, irq}, 32'd0);
    @(negedge clk); in_valid = 1'b0;
    check("R8 irq one cycle after violation", {31'd0, irq}, 32'd1);
    rd_reg(12'h004, rd); check("R8 status first", rd, 32'h5);
    rd_reg(12'h008, rd); check("R8 captured addr", rd, 32'h4000_0000);
    rd_reg(12'h00C, rd); check("R8 captured id", rd, 32'h033);
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h5000_0000; in_id = 10'h044; in_write = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    rd_reg(12'h004, rd); check("R8 overflow set", rd, 32'h7);
    rd_reg(12'h008, rd); check("R8 first record kept", rd, 32'h4000_0000);

    // R11 foreign clear ignored
    apb(1'b1, 12'h010, 32'h1, OTHER, rd, err);
    check("R11 foreign write pslverr", {31'd0, err}, 32'd1);
    check("R11 irq still set", {31'd0, irq}, 32'd1);
    apb(1'b1, 12'h11C, 32'h7, OTHER, rd, err);
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h2000_0010; in_id = 10'h001; in_write = 1'b1; out_ready = 1'b0;
    #1; check("R11 foreign region write ignored", {31'd0, out_user[10]}, 32'd1);
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;

    // R9 clear
    apb(1'b1, 12'h010, 32'h1, OWN, rd, err);
    check("R9 owner clear no error", {31'd0, err}, 32'd0);
    check("R9 irq dropped", {31'd0, irq}, 32'd0);
    rd_reg(12'h004, rd); check("R9 status zero", rd, 32'd0);

    // R10 lock
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h4000_0000; in_id = 10'h033; in_write = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    wr_reg(12'h000, 32'h3);
    rd_reg(12'h000, rd); check("R10 lock set", rd, 32'h3);
    apb(1'b1, 12'h010, 32'h1, OWN, rd, err);
    check("R10 locked clear pslverr", {31'd0, err}, 32'd1);
    check("R10 irq held under lock", {31'd0, irq}, 32'd1);
    apb(1'b1, 12'h000, 32'h0, OWN, rd, err);
    check("R10 locked ctrl pslverr", {31'd0, err}, 32'd1);
    rd_reg(12'h000, rd); check("R10 lock sticky", rd, 32'h3);
    apb(1'b1, 12'h11C, 32'h7, OWN, rd, err);
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h2000_0010; in_id = 10'h001; in_write = 1'b1; out_ready = 1'b0;
    #1; check("R10 locked region write ignored", {31'd0, out_user[10]}, 32'd1);
    @(negedge clk); in_valid = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule